// File: doc/BRIEF.md
# Dual Interval Timers with Watchdog

This block holds two 16-bit up-counting interval timers and a retriggerable watchdog discrete. The fast timer advances once every 10 µs and the slow timer once every 100 µs. Both tick rates come from the system clock through prescalers, and the prescalers are sized from a clock-frequency parameter. The watchdog output ("GO") rises when software triggers it. It falls after a fixed hold time unless software triggers it again before that time runs out, so a stuck program shows up as a falling edge.

Software drives the block through a single command port. A command is one 16-bit code plus a 16-bit operand, presented with a valid strobe for one clock cycle. For each timer the commands are start, halt, load and read. A further command retriggers the watchdog. Read commands return the selected timer value on a combinational read bus in the same cycle. Both timer values are also visible on ports at all times. Each timer has its own overflow pulse.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both timers read 0x0000 and are halted, both overflow pulses are low, and the watchdog output is low.
- R2: The fast timer advances by one every CLK_HZ/100000 clock cycles (10 µs) while it runs. Command 0x4008 starts it from its current value without changing the value.
- R3: Command 0x4009 (fast) or 0x400D (slow) halts a timer. The value then stays frozen until a start or load command. After a start, the next increment comes no later than one tick period.
- R4: Command 0x400A (fast) or 0x400E (slow) loads the operand into the timer in the cycle after the command and sets the timer running. The first increment after the load comes exactly one full tick period after it.
- R5: A timer steps from 0xFFFF to 0x0000. In the cycle where it shows 0x0000 after that wrap, its overflow output is high for exactly one clock cycle.
- R6: The slow timer advances by one every CLK_HZ/10000 clock cycles (100 µs) while it runs. Command 0x400C starts it.
- R7: While a valid command carries 0xC00A (fast) or 0xC00E (slow), the read bus shows that timer's current value. The read does not change the timer. With no read command present, the read bus is 0x0000.
- R8: Command 0x400B drives the watchdog output high for exactly CLK_HZ/1000000*GO_HOLD_US cycles. A new trigger while the output is high restarts the full hold time.
- R9: Codes outside the recognised set, and any code presented without the valid strobe, change no timer and no watchdog state.
- R10: Commands for one timer have no effect on the other timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdCode | input | 16 | Command code |
| cmdData | input | 16 | Operand for load commands |
| rdData | output | 16 | Timer value returned by a read command, otherwise zero |
| timerA | output | 16 | Fast (10 µs) timer value |
| timerB | output | 16 | Slow (100 µs) timer value |
| ovfA | output | 1 | One-cycle pulse when the fast timer wraps |
| ovfB | output | 1 | One-cycle pulse when the slow timer wraps |
| goOut | output | 1 | Watchdog discrete |

## Verification
The bench measures the exact cycle of the first increment after a load. A design that left the prescaler running through the load would step early and fail that check. Halt is checked over several tick periods: a design whose prescaler kept counting while halted, or whose halt lost to a coincident tick, would show a moving value. Wraps are driven by loading 0xFFFE or 0xFFFF into each timer. These tests catch an overflow pulse that is missing, lasts two cycles or falls in the wrong cycle. The watchdog is retriggered partway through its hold time, and the fall must come a full hold time after the second trigger; a design that ignored retriggers would drop early. Unknown codes, unstrobed codes and cross-timer commands are checked for side effects at the value ports.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [15:0] CMD_A_START = 16'h4008;
  localparam logic [15:0] CMD_A_HALT  = 16'h4009;
  localparam logic [15:0] CMD_A_LOAD  = 16'h400A;
  localparam logic [15:0] CMD_GO      = 16'h400B;
  localparam logic [15:0] CMD_B_START = 16'h400C;
  localparam logic [15:0] CMD_B_HALT  = 16'h400D;
  localparam logic [15:0] CMD_B_LOAD  = 16'h400E;
  localparam logic [15:0] CMD_A_READ  = 16'hC00A;
  localparam logic [15:0] CMD_B_READ  = 16'hC00E;

  typedef struct packed {
    logic start;
    logic halt;
    logic load;
  } chan_strb_t;

  typedef struct packed {
    chan_strb_t a;
    chan_strb_t b;
    logic       goTrig;
    logic       readA;
    logic       readB;
  } tmr_strb_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdCode,
  output tmr_strb_t   strb
);
  always_comb begin
    strb = '0;
    if (cmdValid) begin
      unique case (cmdCode)
        CMD_A_START: strb.a.start = 1'b1;
        CMD_A_HALT:  strb.a.halt  = 1'b1;
        CMD_A_LOAD:  strb.a.load  = 1'b1;
        CMD_B_START: strb.b.start = 1'b1;
        CMD_B_HALT:  strb.b.halt  = 1'b1;
        CMD_B_LOAD:  strb.b.load  = 1'b1;
        CMD_GO:      strb.goTrig  = 1'b1;
        CMD_A_READ:  strb.readA   = 1'b1;
        CMD_B_READ:  strb.readB   = 1'b1;
        default:     strb = '0;
      endcase
    end
  end

  // R9: at most one action per command, none without the strobe
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
  a_r9_no_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (strb == '0));
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_pkg::*;
#(
  parameter int PRE = 10,
  parameter int W   = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  chan_strb_t   strb,
  input  logic [W-1:0] loadData,
  output logic [W-1:0] value,
  output logic         ovf
);
  localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE - 1);

  logic          running;
  logic [PW-1:0] presc;
  logic          tick;

  assign tick = running && !strb.halt && !strb.load && (presc == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      presc   <= '0;
      value   <= '0;
      ovf     <= 1'b0;
    end else begin
      ovf <= tick && (value == {W{1'b1}});
      if (strb.load) begin
        value   <= loadData;
        presc   <= '0;
        running <= 1'b1;
      end else begin
        if (strb.start) running <= 1'b1;
        if (strb.halt)  running <= 1'b0;
        if (running && !strb.halt) begin
          if (tick) begin
            presc <= '0;
            value <= value + 1'b1;
          end else begin
            presc <= presc + 1'b1;
          end
        end
      end
    end
  end

  // R3: a halted timer without a load holds its value
  a_r3_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.load) |=> $stable(value));
  // R4: load lands in the next cycle
  a_r4_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (value == $past(loadData)));
  // R5: overflow pulse coincides with zero and lasts one cycle
  a_r5_ovf_zero: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (value == '0));
  a_r5_ovf_single: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> !ovf);
  // R2: prescaler stays within its tick period
  a_r2_presc_range: assert property (@(posedge clk) disable iff (!rstN)
    presc <= PRE_LAST);
endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
#(
  parameter int PRE_A   = 1250,
  parameter int PRE_B   = 12500,
  parameter int GO_HOLD = 125000,
  parameter int W       = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmr_strb_t    strb,
  input  logic [W-1:0] cmdData,
  output logic [W-1:0] rdData,
  output logic [W-1:0] timerA,
  output logic [W-1:0] timerB,
  output logic         ovfA,
  output logic         ovfB,
  output logic         goOut
);
  localparam int GW = $clog2(GO_HOLD + 1);
  localparam int NCH = 2;

  logic [NCH-1:0][W-1:0] vals;
  logic [NCH-1:0]        ovfs;
  chan_strb_t [NCH-1:0]  chStrb;

  assign chStrb[0] = strb.a;
  assign chStrb[1] = strb.b;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    timer_chan #(.PRE((i == 0) ? PRE_A : PRE_B), .W(W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (chStrb[i]),
      .loadData (cmdData),
      .value    (vals[i]),
      .ovf      (ovfs[i])
    );
  end

  assign timerA = vals[0];
  assign timerB = vals[1];
  assign ovfA   = ovfs[0];
  assign ovfB   = ovfs[1];

  always_comb begin
    rdData = '0;
    if (strb.readA)      rdData = vals[0];
    else if (strb.readB) rdData = vals[1];
  end

  logic [GW-1:0] goCnt;
  always_ff @(posedge clk) begin
    if (!rstN)            goCnt <= '0;
    else if (strb.goTrig) goCnt <= GW'(GO_HOLD);
    else if (goCnt != '0) goCnt <= goCnt - 1'b1;
  end
  assign goOut = (goCnt != '0);

  // R8: a trigger raises the output; it only falls without a trigger
  a_r8_go_rise: assert property (@(posedge clk) disable iff (!rstN)
    strb.goTrig |=> goOut);
  a_r8_go_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(goOut) |-> !$past(strb.goTrig));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import timer_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int GO_HOLD_US = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdCode,
  input  logic [15:0] cmdData,
  output logic [15:0] rdData,
  output logic [15:0] timerA,
  output logic [15:0] timerB,
  output logic        ovfA,
  output logic        ovfB,
  output logic        goOut
);
  localparam int PRE_A   = CLK_HZ / 100_000;
  localparam int PRE_B   = CLK_HZ / 10_000;
  localparam int GO_HOLD = (CLK_HZ / 1_000_000) * GO_HOLD_US;

  tmr_strb_t strb;

  timer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .strb     (strb)
  );

  timer_dp #(.PRE_A(PRE_A), .PRE_B(PRE_B), .GO_HOLD(GO_HOLD), .W(16)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdData (cmdData),
    .rdData  (rdData),
    .timerA  (timerA),
    .timerB  (timerB),
    .ovfA    (ovfA),
    .ovfB    (ovfB),
    .goOut   (goOut)
  );
endmodule

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
  localparam int CLK_HZ = 1_000_000;
  localparam int HOLD_US = 40;
  localparam int PA = CLK_HZ / 100_000;
  localparam int PB = CLK_HZ / 10_000;
  localparam int HOLD = (CLK_HZ / 1_000_000) * HOLD_US;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [15:0] cmdCode = '0;
  logic [15:0] cmdData = '0;
  logic [15:0] rdData, timerA, timerB;
  logic ovfA, ovfB, goOut;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  dual_interval_timer #(.CLK_HZ(CLK_HZ), .GO_HOLD_US(HOLD_US)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdData(cmdData), .rdData(rdData), .timerA(timerA), .timerB(timerB),
    .ovfA(ovfA), .ovfB(ovfB), .goOut(goOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] code, input logic [15:0] data, input logic vld = 1'b1);
    @(negedge clk);
    cmdValid = vld; cmdCode = code; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = '0; cmdData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 timerA", {16'h0, timerA}, 32'h0);
    check("R1 timerB", {16'h0, timerB}, 32'h0);
    check("R1 ovf/go", {29'h0, ovfA, ovfB, goOut}, 32'h0);
    idle(2 * PB);
    check("R1 halted A", {16'h0, timerA}, 32'h0);
    check("R1 halted B", {16'h0, timerB}, 32'h0);
  endtask

  task automatic t_start_a;
    issue(16'h4008, 16'h0);
    check("R2 start keeps value", {16'h0, timerA}, 32'h0);
    idle(PA - 1);
    check("R2 before tick", {16'h0, timerA}, 32'h0);
    idle(1);
    check("R2 first tick", {16'h0, timerA}, 32'h1);
    idle(3 * PA);
    check("R2 rate", {16'h0, timerA}, 32'h4);
    check("R10 B untouched", {16'h0, timerB}, 32'h0);
  endtask

  task automatic t_halt_a;
    logic [15:0] v;
    issue(16'h4009, 16'h0);
    v = timerA;
    idle(4 * PA);
    check("R3 halt freezes A", {16'h0, timerA}, {16'h0, v});
    issue(16'h4008, 16'h0);
    idle(PA);
    check("R3 resume A", {16'h0, timerA}, {16'h0, v + 16'h1});
  endtask

  task automatic t_load_a;
    issue(16'h400A, 16'h1234);
    check("R4 load A", {16'h0, timerA}, 32'h1234);
    idle(PA - 1);
    check("R4 no early tick", {16'h0, timerA}, 32'h1234);
    idle(1);
    check("R4 full tick after load", {16'h0, timerA}, 32'h1235);
  endtask

  task automatic t_wrap_a;
    issue(16'h400A, 16'hFFFE);
    idle(PA);
    check("R5 A at FFFF", {15'h0, ovfA, timerA}, 32'h0FFFF);
    idle(PA - 1);
    check("R5 no early ovf", {15'h0, ovfA, timerA}, 32'h0FFFF);
    idle(1);
    check("R5 wrap pulse", {15'h0, ovfA, timerA}, 32'h10000);
    idle(1);
    check("R5 pulse one cycle", {31'h0, ovfA}, 32'h0);
    issue(16'h4009, 16'h0);
  endtask

  task automatic t_timer_b;
    logic [15:0] a0;
    a0 = timerA;
    issue(16'h400E, 16'hFFFF);
    check("R4 load B", {16'h0, timerB}, 32'hFFFF);
    idle(PB - 1);
    check("R6 B before tick", {15'h0, ovfB, timerB}, 32'h0FFFF);
    idle(1);
    check("R6 B tick+wrap R5", {15'h0, ovfB, timerB}, 32'h10000);
    idle(1);
    check("R5 B pulse one cycle", {31'h0, ovfB}, 32'h0);
    check("R10 A untouched by B", {16'h0, timerA}, {16'h0, a0});
    issue(16'h400D, 16'h0);
    a0 = timerB;
    idle(2 * PB);
    check("R3 halt freezes B", {16'h0, timerB}, {16'h0, a0});
    issue(16'h400C, 16'h0);
    idle(PB);
    check("R6 start B", {16'h0, timerB}, {16'h0, a0 + 16'h1});
    issue(16'h400D, 16'h0);
  endtask

  task automatic t_read;
    logic [15:0] v;
    issue(16'h400A, 16'h00AB);
    issue(16'h4009, 16'h0);
    v = timerA;
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 16'hC00A;
    #1 check("R7 read A", {16'h0, rdData}, {16'h0, v});
    cmdCode = 16'hC00E;
    #1 check("R7 read B", {16'h0, rdData}, {16'h0, timerB});
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = '0;
    #1 check("R7 idle bus", {16'h0, rdData}, 32'h0);
    check("R7 read keeps A", {16'h0, timerA}, {16'h0, v});
  endtask

  task automatic t_go;
    issue(16'h400B, 16'h0);
    check("R8 go high", {31'h0, goOut}, 32'h1);
    idle(HOLD - 1);
    check("R8 go held", {31'h0, goOut}, 32'h1);
    idle(1);
    check("R8 go drops", {31'h0, goOut}, 32'h0);
    issue(16'h400B, 16'h0);
    idle(HOLD / 2);
    issue(16'h400B, 16'h0);
    idle(HOLD - 1);
    check("R8 retrigger extends", {31'h0, goOut}, 32'h1);
    idle(1);
    check("R8 retrigger drop", {31'h0, goOut}, 32'h0);
  endtask

  task automatic t_ignored;
    logic [15:0] a0, b0;
    a0 = timerA; b0 = timerB;
    issue(16'h4010, 16'h5555);
    issue(16'h400A, 16'h7777, 1'b0);
    issue(16'h400B, 16'h0, 1'b0);
    issue(16'h0008, 16'h1111);
    idle(2 * PB);
    check("R9 A unchanged", {16'h0, timerA}, {16'h0, a0});
    check("R9 B unchanged", {16'h0, timerB}, {16'h0, b0});
    check("R9 go low", {31'h0, goOut}, 32'h0);
  endtask

  initial begin
    #150_000_0;
    $display("FAIL watchdog: actual timeout expected completion");
    nFails++;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_a();
    t_halt_a();
    t_load_a();
    t_wrap_a();
    t_timer_b();
    t_read();
    t_go();
    t_ignored();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule